// File: doc/BRIEF.md
# Audio Codec Power-Up and Register Setup Sequencer

This block brings an audio codec from reset to a playing state by issuing a fixed list of register writes over a two-wire control bus. It never touches the bus pins itself. Each write is handed to a separate byte-level write engine as two bytes, and the sequencer waits for that engine to report completion before it offers the next one. The list has a fixed shape: a first power write that wakes the codec blocks with the output stage still off, a parameterised run of configuration writes, a write that activates the digital core, a settle delay, and a last power write that turns the output stage on.

Register addresses and data words are parameters, as is the length of the settle delay. A pulse on `start` launches the sequence. When the last write is acknowledged, the block raises `seq_done` and releases the active-low `mute_n` output. If the write engine reports a missing acknowledge, the sequence halts, `seq_err` is raised and the codec stays muted. A new `start` after completion or after an error runs the list again from its first entry. While the list is running, `start` has no effect.

Top module: `codec_init_seq`

## Requirements
- R1: After a synchronous reset, `cmd_valid`, `seq_done`, `seq_err` and `mute_n` are all low, and they stay low until `start` is seen.
- R2: Each write carries a 7-bit register address and a 9-bit data word. `cmd_byte0` holds the address in bits 7:1 and data bit 8 in bit 0. `cmd_byte1` holds data bits 7:0.
- R3: With the default parameters the writes go out in exactly this order, given as (address, data) in hex: (06,010) powers the blocks with bit 4 set, which keeps the output stage off; (04,010) sets the DAC-select bit 4; (05,000) clears the DAC soft-mute bit 3; (07,00A) sets the audio interface format; (08,000) sets the sample rate; (09,001) activates the digital core; (06,000) powers the output stage.
- R4: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and both bytes stay unchanged.
- R5: Only one write is outstanding at a time. After a write is accepted, the next write is offered in the cycle after the `cmd_done` pulse, and never earlier.
- R6: Between the acknowledge of the core-activation write and the offer of the final power write, `cmd_valid` stays low for exactly SETTLE_CYCLES cycles. Between every other pair of writes there is no idle cycle.
- R7: After the final write is acknowledged without error, `seq_done` and `mute_n` go high together and stay high until the next `start`.
- R8: A `cmd_done` pulse with `cmd_err` high stops the sequence. `seq_err` goes high, `seq_done` and `mute_n` stay low, and no further write is offered.
- R9: A `start` pulse while the sequence is running has no effect: the list continues where it was and no entry is repeated.
- R10: A `start` in the done or error state restarts from the first entry, and `mute_n` goes low again for the whole run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches the sequence when not running |
| cmd_valid | output | 1 | A write is offered to the write engine |
| cmd_byte0 | output | 8 | Register address and data bit 8 |
| cmd_byte1 | output | 8 | Data bits 7:0 |
| cmd_ready | input | 1 | Write engine accepts the offered write |
| cmd_done | input | 1 | One-cycle completion pulse for the accepted write |
| cmd_err | input | 1 | Qualifies `cmd_done`: no acknowledge was received |
| seq_done | output | 1 | Sequence finished without error |
| seq_err | output | 1 | Sequence stopped on a missing acknowledge |
| mute_n | output | 1 | Active-low codec mute, high only after a clean run |

## Verification
The in-line assertions check on every cycle that an offered write holds steady until it is accepted, that `mute_n` follows completion exactly, that the error state stays quiet on the bus, and that the settle counter stays in range. Some behaviour can only be shown by the bench's scenarios: the exact order and byte contents of the list, the length of the settle gap compared with the back-to-back gaps, a halt at any randomly chosen entry on a missing acknowledge, the disregard of `start` in mid-run, and restarts from both end states under random ready and acknowledge latencies.

// File: rtl/codec_init_pkg.sv
package codec_init_pkg;

    localparam int REG_ADDR_W = 7;
    localparam int REG_DATA_W = 9;
    localparam int WORD_W     = REG_ADDR_W + REG_DATA_W;

    typedef struct packed {
        logic [REG_ADDR_W-1:0] addr;
        logic [REG_DATA_W-1:0] data;
    } codec_wr_t;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_ISSUE  = 3'd1,
        PH_WAIT   = 3'd2,
        PH_SETTLE = 3'd3,
        PH_DONE   = 3'd4,
        PH_FAIL   = 3'd5
    } seq_phase_t;

    // High byte: address followed by data MSB.
    function automatic logic [7:0] wr_hi_byte(codec_wr_t w);
        return {w.addr, w.data[REG_DATA_W-1]};
    endfunction

    function automatic logic [7:0] wr_lo_byte(codec_wr_t w);
        return w.data[7:0];
    endfunction

    function automatic logic phase_running(seq_phase_t p);
        return (p == PH_ISSUE) || (p == PH_WAIT) || (p == PH_SETTLE);
    endfunction

endpackage

// File: rtl/cis_script_rom.sv
module cis_script_rom
    import codec_init_pkg::*;
#(
    parameter int                      N_CFG     = 4,
    parameter logic [N_CFG*WORD_W-1:0] CFG_LIST  = '0,
    parameter logic [WORD_W-1:0]       PWR_FIRST = '0,
    parameter logic [WORD_W-1:0]       CORE_ON   = '0,
    parameter logic [WORD_W-1:0]       PWR_LAST  = '0,
    localparam int                     N_TOTAL   = N_CFG + 3,
    localparam int                     IDX_W     = $clog2(N_TOTAL)
) (
    input  logic [IDX_W-1:0] idx,
    output codec_wr_t        word
);

    codec_wr_t table_w [N_TOTAL];

    assign table_w[0]         = codec_wr_t'(PWR_FIRST);
    assign table_w[N_CFG + 1] = codec_wr_t'(CORE_ON);
    assign table_w[N_CFG + 2] = codec_wr_t'(PWR_LAST);

    for (genvar i = 0; i < N_CFG; i++) begin : g_cfg
        assign table_w[i + 1] = codec_wr_t'(CFG_LIST[i*WORD_W +: WORD_W]);
    end

    always_comb begin
        word = '0;
        for (int k = 0; k < N_TOTAL; k++) begin
            if (idx == IDX_W'(k)) word = table_w[k];
        end
    end

endmodule

// File: rtl/cis_settle_timer.sv
module cis_settle_timer #(
    parameter int  CYCLES = 1000,
    localparam int CNT_W  = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    assign expire = run && (cnt_q == CNT_W'(CYCLES - 1));

    // R6: the count never passes the settle length
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < CNT_W'(CYCLES)));

    // R6: once the delay expires the controller leaves the wait
    p_expire_leaves_r6: assert property (@(posedge clk) disable iff (rst)
        expire |=> !run || (cnt_q == '0));

endmodule

// File: rtl/codec_init_seq.sv
module codec_init_seq
    import codec_init_pkg::*;
#(
    parameter int                      SETTLE_CYCLES = 1000000,
    parameter int                      N_CFG         = 4,
    parameter logic [N_CFG*WORD_W-1:0] CFG_LIST      = 64'h1000_0E0A_0A00_0810,
    parameter logic [WORD_W-1:0]       PWR_FIRST     = 16'h0C10,
    parameter logic [WORD_W-1:0]       CORE_ON       = 16'h1201,
    parameter logic [WORD_W-1:0]       PWR_LAST      = 16'h0C00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output logic       cmd_valid,
    output logic [7:0] cmd_byte0,
    output logic [7:0] cmd_byte1,
    input  logic       cmd_ready,
    input  logic       cmd_done,
    input  logic       cmd_err,
    output logic       seq_done,
    output logic       seq_err,
    output logic       mute_n
);

    localparam int N_TOTAL = N_CFG + 3;
    localparam int IDX_W   = $clog2(N_TOTAL);
    localparam int LAST    = N_TOTAL - 1;

    seq_phase_t       phase_q, phase_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    codec_wr_t        cur_word;
    logic             settle_exp;

    cis_script_rom #(
        .N_CFG    (N_CFG),
        .CFG_LIST (CFG_LIST),
        .PWR_FIRST(PWR_FIRST),
        .CORE_ON  (CORE_ON),
        .PWR_LAST (PWR_LAST)
    ) u_rom (
        .idx (idx_q),
        .word(cur_word)
    );

    cis_settle_timer #(
        .CYCLES(SETTLE_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (phase_q == PH_SETTLE),
        .expire(settle_exp)
    );

    always_comb begin
        phase_d = phase_q;
        idx_d   = idx_q;
        unique case (phase_q)
            PH_IDLE, PH_DONE, PH_FAIL: begin
                if (start) begin
                    phase_d = PH_ISSUE;
                    idx_d   = '0;
                end
            end
            PH_ISSUE: begin
                if (cmd_ready) phase_d = PH_WAIT;
            end
            PH_WAIT: begin
                if (cmd_done) begin
                    if (cmd_err) begin
                        phase_d = PH_FAIL;
                    end else if (idx_q == IDX_W'(LAST)) begin
                        phase_d = PH_DONE;
                    end else begin
                        idx_d   = idx_q + 1'b1;
                        phase_d = (idx_q + 1'b1 == IDX_W'(LAST)) ? PH_SETTLE : PH_ISSUE;
                    end
                end
            end
            PH_SETTLE: begin
                if (settle_exp) phase_d = PH_ISSUE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
        end
    end

    assign cmd_valid = (phase_q == PH_ISSUE);
    assign cmd_byte0 = wr_hi_byte(cur_word);
    assign cmd_byte1 = wr_lo_byte(cur_word);
    assign seq_done  = (phase_q == PH_DONE);
    assign seq_err   = (phase_q == PH_FAIL);
    assign mute_n    = (phase_q == PH_DONE);

    // R4: an offered write holds until accepted
    p_hold_offer_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_byte0) && $stable(cmd_byte1));

    // R7: mute release coincides with completion
    p_mute_done_r7: assert property (@(posedge clk) disable iff (rst)
        mute_n == seq_done);

    // R7: completion holds until a new start
    p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
        seq_done && !start |=> seq_done);

    // R8: the error state is quiet and exclusive
    p_fail_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        seq_err |-> !cmd_valid && !seq_done && !mute_n);

    // R8: an error stays until a new start
    p_fail_hold_r8: assert property (@(posedge clk) disable iff (rst)
        seq_err && !start |=> seq_err);

    // R9: start during a run does not rewind the list
    p_no_rewind_r9: assert property (@(posedge clk) disable iff (rst)
        phase_running(phase_q) && start && !cmd_done |=> $stable(idx_q));

    // R1: nothing happens before the first start
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE) |-> !cmd_valid && !seq_done && !seq_err && !mute_n);

endmodule

// File: tb/codec_init_seq_tb.sv
`timescale 1ns/100ps
module codec_init_seq_tb;

    localparam int S_CYC   = 20;
    localparam int N_WR    = 7;
    localparam int LAST_IX = N_WR - 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       cmd_valid;
    logic [7:0] cmd_byte0, cmd_byte1;
    logic       cmd_ready = 1'b0;
    logic       cmd_done  = 1'b0;
    logic       cmd_err   = 1'b0;
    logic       seq_done, seq_err, mute_n;

    always #2.5 clk = ~clk;

    codec_init_seq #(.SETTLE_CYCLES(S_CYC)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .cmd_valid(cmd_valid), .cmd_byte0(cmd_byte0), .cmd_byte1(cmd_byte1),
        .cmd_ready(cmd_ready), .cmd_done(cmd_done), .cmd_err(cmd_err),
        .seq_done(seq_done), .seq_err(seq_err), .mute_n(mute_n)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 0;

    // Expected list from R3: {addr[6:0], data[8:0]}
    function automatic logic [15:0] exp_word(int i);
        case (i)
            0: return {7'h06, 9'h010};
            1: return {7'h04, 9'h010};
            2: return {7'h05, 9'h000};
            3: return {7'h07, 9'h00A};
            4: return {7'h08, 9'h000};
            5: return {7'h09, 9'h001};
            default: return {7'h06, 9'h000};
        endcase
    endfunction

    // R2 packing computed in the bench
    function automatic logic [15:0] exp_bytes(int i);
        logic [15:0] w = exp_word(i);
        return {w[15:9], w[8], w[7:0]};
    endfunction

    function automatic int exp_gap(int i);
        return (i == LAST_IX) ? S_CYC : 0;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Responder model of the write engine
    int nack_at   = -1;
    int acc_count = 0;
    int cur_ix    = 0;
    int ph        = 0;
    int dly       = 0;

    always @(posedge clk) begin
        if (rst) begin
            cmd_ready <= 1'b0; cmd_done <= 1'b0; cmd_err <= 1'b0;
            ph <= 0; dly <= 0;
        end else begin
            case (ph)
                0: if (cmd_valid) begin
                       if (dly == 0) begin cmd_ready <= 1'b1; ph <= 1; end
                       else dly <= dly - 1;
                   end
                1: begin
                       cmd_ready <= 1'b0;
                       cur_ix    <= acc_count;
                       acc_count <= acc_count + 1;
                       dly       <= int'($urandom_range(0, 4));
                       ph        <= 2;
                   end
                2: if (dly == 0) begin
                       cmd_done <= 1'b1;
                       cmd_err  <= (cur_ix == nack_at);
                       ph       <= 3;
                   end else dly <= dly - 1;
                default: begin
                       cmd_done <= 1'b0; cmd_err <= 1'b0;
                       dly      <= int'($urandom_range(0, 3));
                       ph       <= 0;
                   end
            endcase
        end
    end

    // Monitor: log accepted writes, gaps and hold violations
    logic [15:0] log_w [16];
    int          gaps  [16];
    int          nlog   = 0;
    int          nvalid = 0;
    bit          armed  = 0;
    int          gap    = 0;
    bit          prev_v = 0;
    bit          prev_wait = 0;
    logic [15:0] prev_b = '0;
    int          hold_bad = 0;
    bit          prev_valid = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_wait && (!cmd_valid || {cmd_byte0, cmd_byte1} != prev_b)) hold_bad++;
            prev_wait = cmd_valid && !cmd_ready;
            prev_b    = {cmd_byte0, cmd_byte1};
            if (cmd_valid && !prev_valid && nvalid < 16) begin
                gaps[nvalid] = armed ? gap : -1;
                nvalid++;
                armed = 0;
            end else if (armed) gap++;
            if (cmd_done) begin armed = 1; gap = 0; end
            if (cmd_valid && cmd_ready && nlog < 16) begin
                log_w[nlog] = {cmd_byte0, cmd_byte1};
                nlog++;
            end
            prev_valid = cmd_valid;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic clear_log();
        nlog = 0; nvalid = 0; armed = 0; gap = 0; acc_count = 0; hold_bad = 0;
        prev_valid = 0;
    endtask

    task automatic pulse_start();
        tick(1);
        start = 1'b1;
        tick(1);
        start = 1'b0;
    endtask

    task automatic wait_end(output bit ok);
        ok = 0;
        for (int i = 0; i < 2000; i++) begin
            tick(1);
            if (seq_done || seq_err) begin ok = 1; break; end
        end
    endtask

    task automatic check_full_run(string tag);
        check(seq_done && !seq_err, "R7", {tag, " done"}, {seq_done, seq_err}, 2'b10);
        check(mute_n, "R7", {tag, " mute_n"}, mute_n, 1);
        check(nlog == N_WR, "R3", {tag, " write count"}, nlog, N_WR);
        for (int i = 0; i < N_WR; i++) begin
            check(log_w[i] == exp_bytes(i), "R2/R3", $sformatf("%s entry %0d", tag, i),
                  log_w[i], exp_bytes(i));
        end
        for (int i = 1; i < N_WR; i++) begin
            check(gaps[i] == exp_gap(i), (i == LAST_IX) ? "R6" : "R5",
                  $sformatf("%s gap before %0d", tag, i), gaps[i], exp_gap(i));
        end
        check(hold_bad == 0, "R4", {tag, " offer held until ready"}, hold_bad, 0);
    endtask

    initial begin
        bit ok;
        void'($urandom(32'h5EED_0042));
        tick(4);
        rst = 1'b0;
        tick(3);
        // R1 reset state
        check(!cmd_valid, "R1", "cmd_valid after reset", cmd_valid, 0);
        check(!seq_done,  "R1", "seq_done after reset", seq_done, 0);
        check(!seq_err,   "R1", "seq_err after reset", seq_err, 0);
        check(!mute_n,    "R1", "mute_n after reset", mute_n, 0);

        // Clean first run
        clear_log(); nack_at = -1;
        pulse_start();
        check(!mute_n, "R10", "mute_n low while running", mute_n, 0);
        wait_end(ok);
        check(ok, "R7", "run 1 ended", ok, 1);
        tick(5);
        check_full_run("run1");
        check(seq_done && mute_n, "R7", "done held", {seq_done, mute_n}, 2'b11);

        // Restart after done with start pulses in mid-run (R9, R10)
        clear_log();
        pulse_start();
        check(!mute_n && !seq_done, "R10", "restart drops mute", {seq_done, mute_n}, 0);
        tick(6);
        pulse_start();
        tick(15);
        pulse_start();
        wait_end(ok);
        tick(5);
        check(ok, "R9", "run 2 ended", ok, 1);
        check_full_run("run2_r9");

        // Missing acknowledge at random entries, then restart from error
        for (int r = 0; r < 6; r++) begin
            int k = (r == 0) ? 0 : (r == 1) ? LAST_IX : int'($urandom_range(0, LAST_IX));
            clear_log(); nack_at = k;
            pulse_start();
            wait_end(ok);
            tick(40);
            check(seq_err && !seq_done, "R8", $sformatf("nack at %0d flags", k),
                  {seq_err, seq_done}, 2'b10);
            check(!mute_n, "R8", $sformatf("nack at %0d mute", k), mute_n, 0);
            check(nlog == k + 1, "R8", $sformatf("nack at %0d writes", k), nlog, k + 1);
            check(!cmd_valid, "R8", "no offer after error", cmd_valid, 0);
            clear_log(); nack_at = -1;
            pulse_start();
            check(!seq_err && !mute_n, "R10", "restart from error", {seq_err, mute_n}, 0);
            wait_end(ok);
            tick(5);
            check_full_run($sformatf("r10_after_err%0d", r));
        end

        // Start while idle in done but held long: nothing changes without start
        tick(50);
        check(seq_done && mute_n && !cmd_valid, "R7", "done stable idle",
              {seq_done, mute_n, cmd_valid}, 3'b110);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule